// File: doc/BRIEF.md
# Level-Prioritized Interrupt Controller

This block gathers interrupt requests from a fixed set of lines and holds them in a pending register. It combines that register with a software-written enable register and offers the core the highest priority level that beats the level the core is already running at. Each line gets a priority level (1 to `NUM_LEVELS`) and a trigger type when the block is built. A level-type line releases its pending bit when its source goes inactive. An edge-type line keeps its bit until it is cleared through a write-one-to-clear port.

Line activity arrives as single events on one port: a line index plus an active/inactive flag. Each arbitration level has a line mask derived from the parameters. The masks are scanned from the top level down to the core's current level, and the first level with an enabled pending line wins. The block also includes a small fixed table that turns an external-interrupt number into an internal line number and flags numbers outside the table.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: An event with `evt_valid_i=1`, `evt_active_i=1` and index below `NUM_LINES` sets that line's bit in `pend_o` on the next clock edge.
- R2: An inactive event (`evt_active_i=0`) clears the line's pending bit on the next edge when the line is level-type (its `EDGE_MASK` bit is 0). An edge-type line (`EDGE_MASK` bit 1) keeps its bit.
- R3: An event whose index is `NUM_LINES` or larger changes no pending bit.
- R4: A write with `en_we_i=1` loads `en_wdata_i` into `en_o` on the next edge. Only lines set in both `pend_o` and `en_o` take part in arbitration.
- R5: The selected level L is the highest level for which both hold: L > `cur_level_i`, and some enabled pending line has level L. When such a level exists, `sel_level_o=L` and `core_req_o=1`.
- R6: When no level qualifies, `sel_level_o=0` and `core_req_o=0`.
- R7: Selection is combinational. A change of `cur_level_i` or of the register contents appears on `sel_level_o` and `core_req_o` with no clock edge in between.
- R8: When `ext_idx_i` is below `NUM_EXT`, `ext_valid_o=1` and `ext_line_o` holds entry `ext_idx_i` of `EXT_MAP`. At or beyond `NUM_EXT`, `ext_valid_o=0` and `ext_line_o=0`.
- R9: A write with `clr_we_i=1` clears the pending bits of edge-type lines whose `clr_wdata_i` bit is 1. Level-type bits are unaffected. An active event on the same line in the same cycle wins, and the bit stays set.
- R10: While `rst_ni` is low, `pend_o` and `en_o` are zero, `sel_level_o` is 0 and `core_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Line event strobe |
| evt_idx_i | input | IDX_W | Line index of the event (may be out of range) |
| evt_active_i | input | 1 | 1 = line asserted, 0 = line released |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_LINES | New enable register value |
| clr_we_i | input | 1 | Write-one-to-clear strobe for edge-type bits |
| clr_wdata_i | input | NUM_LINES | Bits to clear |
| cur_level_i | input | LVL_W | Core's current interrupt level |
| ext_idx_i | input | EXT_IDX_W | External interrupt number to translate |
| pend_o | output | NUM_LINES | Pending register |
| en_o | output | NUM_LINES | Enable register |
| sel_level_o | output | LVL_W | Selected pending level, 0 when none |
| core_req_o | output | 1 | Interrupt request to the core |
| ext_line_o | output | LINE_W | Internal line for `ext_idx_i` |
| ext_valid_o | output | 1 | `ext_idx_i` is within the table |

## Verification
The hardest case to reach from the ports is a set and a clear colliding on one edge-type line in the same cycle. The stimulus drives an active event and a write-one-to-clear naming that line on the same clock edge, then checks that the bit survives. A lone clear follows to show the bit does drop. Out-of-range indices are chosen so that their low bits alias a line whose pending bit is currently 0, which exposes a truncated index compare. The core level is stepped to equal, sit just below, and sit above the best pending level, so the strict "greater than" threshold is seen from both sides.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = 4,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  input  logic [IDX_W-1:0]     evt_idx_i,
  input  logic                 evt_active_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] clr_wdata_i,
  output logic [NUM_LINES-1:0] pend_o
);

  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] set_vec, rel_vec, clr_vec;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam trig_e TRIG = trig_e'(EDGE_MASK[i]);
    logic hit;
    assign hit        = evt_valid_i && (evt_idx_i == IDX_W'(i));
    assign set_vec[i] = hit && evt_active_i;
    assign rel_vec[i] = hit && !evt_active_i && (TRIG == TRIG_LEVEL);
    assign clr_vec[i] = clr_we_i && clr_wdata_i[i] && (TRIG == TRIG_EDGE);

    assert_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_valid_i && evt_active_i && evt_idx_i == IDX_W'(i)) |=> pend_q[i]);

    if (TRIG == TRIG_LEVEL) begin : g_lvl
      assert_level_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_i && !evt_active_i && evt_idx_i == IDX_W'(i)) |=> !pend_q[i]);
      assert_level_no_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[i] && !(evt_valid_i && evt_idx_i == IDX_W'(i))) |=> pend_q[i]);
    end else begin : g_edge
      assert_edge_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[i] && !(clr_we_i && clr_wdata_i[i])) |=> pend_q[i]);
      assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && clr_wdata_i[i] &&
         !(evt_valid_i && evt_active_i && evt_idx_i == IDX_W'(i))) |=> !pend_q[i]);
    end
  end

  // set beats release and clear in the same cycle
  assign pend_d = (pend_q & ~(rel_vec | clr_vec)) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_ignore_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_idx_i >= IDX_W'(NUM_LINES) && !clr_we_i) |=> $stable(pend_q));

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned NUM_LEVELS = 5,
  parameter int unsigned LVL_W      = 3,
  parameter logic [NUM_LINES*LVL_W-1:0] LINE_LEVEL = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] eff_i,
  input  logic [LVL_W-1:0]     cur_level_i,
  output logic [LVL_W-1:0]     sel_level_o,
  output logic                 req_o
);

  logic [NUM_LEVELS-1:0] hit;

  for (genvar lv = 1; lv <= NUM_LEVELS; lv++) begin : g_lvl
    logic [NUM_LINES-1:0] mask;
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
      assign mask[i] = (LINE_LEVEL[i*LVL_W +: LVL_W] == LVL_W'(lv));
    end
    assign hit[lv-1] = |(mask & eff_i);

    assert_top_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[lv-1] && LVL_W'(lv) > cur_level_i) |-> (req_o && sel_level_o >= LVL_W'(lv)));
  end

  // scan from top level down to just above the core level
  always_comb begin
    logic found;
    found       = 1'b0;
    sel_level_o = '0;
    for (int lv = NUM_LEVELS; lv >= 1; lv--) begin
      if (!found && hit[lv-1] && (LVL_W'(lv) > cur_level_i)) begin
        found       = 1'b1;
        sel_level_o = LVL_W'(lv);
      end
    end
  end

  assign req_o = |sel_level_o;

  assert_above_core_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (sel_level_o > cur_level_i));
  assert_idle_when_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_i == '0) |-> (!req_o && sel_level_o == '0));

endmodule

// File: rtl/irq_ext_map.sv
module irq_ext_map #(
  parameter int unsigned NUM_EXT   = 3,
  parameter int unsigned EXT_IDX_W = 2,
  parameter int unsigned LINE_W    = 3,
  parameter logic [NUM_EXT*LINE_W-1:0] EXT_MAP = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [EXT_IDX_W-1:0] ext_idx_i,
  output logic [LINE_W-1:0]    ext_line_o,
  output logic                 ext_valid_o
);

  always_comb begin
    ext_valid_o = 1'b0;
    ext_line_o  = '0;
    for (int e = 0; e < NUM_EXT; e++) begin
      if (ext_idx_i == EXT_IDX_W'(e)) begin
        ext_valid_o = 1'b1;
        ext_line_o  = EXT_MAP[e*LINE_W +: LINE_W];
      end
    end
  end

  assert_ext_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> (ext_idx_i < EXT_IDX_W'(NUM_EXT)));
  assert_ext_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_idx_i >= EXT_IDX_W'(NUM_EXT)) |-> (!ext_valid_o && ext_line_o == '0));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned NUM_LEVELS = 5,
  parameter int unsigned NUM_EXT    = 3,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1),
  parameter int unsigned LINE_W     = $clog2(NUM_LINES),
  parameter int unsigned IDX_W      = $clog2(NUM_LINES) + 1,
  parameter int unsigned EXT_IDX_W  = $clog2(NUM_EXT + 1),
  // line i level in bits [i*LVL_W +: LVL_W]
  parameter logic [NUM_LINES*LVL_W-1:0] LINE_LEVEL = 24'b101_011_001_101_100_011_010_001,
  parameter logic [NUM_LINES-1:0]       EDGE_MASK  = 8'b1100_1010,
  parameter logic [NUM_EXT*LINE_W-1:0]  EXT_MAP    = 9'b111_101_010
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  input  logic [IDX_W-1:0]     evt_idx_i,
  input  logic                 evt_active_i,
  input  logic                 en_we_i,
  input  logic [NUM_LINES-1:0] en_wdata_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] clr_wdata_i,
  input  logic [LVL_W-1:0]     cur_level_i,
  input  logic [EXT_IDX_W-1:0] ext_idx_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [LVL_W-1:0]     sel_level_o,
  output logic                 core_req_o,
  output logic [LINE_W-1:0]    ext_line_o,
  output logic                 ext_valid_o
);

  logic [NUM_LINES-1:0] pend, en_q, eff;

  irq_pend_reg #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .EDGE_MASK (EDGE_MASK)
  ) u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_valid_i  (evt_valid_i),
    .evt_idx_i    (evt_idx_i),
    .evt_active_i (evt_active_i),
    .clr_we_i     (clr_we_i),
    .clr_wdata_i  (clr_wdata_i),
    .pend_o       (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign eff = pend & en_q;

  irq_level_arb #(
    .NUM_LINES  (NUM_LINES),
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W),
    .LINE_LEVEL (LINE_LEVEL)
  ) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eff_i       (eff),
    .cur_level_i (cur_level_i),
    .sel_level_o (sel_level_o),
    .req_o       (core_req_o)
  );

  irq_ext_map #(
    .NUM_EXT   (NUM_EXT),
    .EXT_IDX_W (EXT_IDX_W),
    .LINE_W    (LINE_W),
    .EXT_MAP   (EXT_MAP)
  ) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_idx_i   (ext_idx_i),
    .ext_line_o  (ext_line_o),
    .ext_valid_o (ext_valid_o)
  );

  assign pend_o = pend;
  assign en_o   = en_q;

  assert_en_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_o == $past(en_wdata_i)));
  assert_masked_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & en_o) == '0) |-> !core_req_o);
  always_comb begin
    if (!rst_ni) assert_reset_R10: assert (core_req_o == 1'b0 || pend == '0 || en_q == '0);
  end

endmodule

// File: tb/sim_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module sim_lvl_irq_ctrl;

  typedef enum {K_PEND, K_EN, K_SEL, K_REQ, K_EXTV, K_EXTL} kind_e;
  typedef struct {
    kind_e k;
    int    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0;
  logic [3:0] evt_idx_i = '0;
  logic       evt_active_i = 1'b0;
  logic       en_we_i = 1'b0;
  logic [7:0] en_wdata_i = '0;
  logic       clr_we_i = 1'b0;
  logic [7:0] clr_wdata_i = '0;
  logic [2:0] cur_level_i = '0;
  logic [1:0] ext_idx_i = '0;
  logic [7:0] pend_o, en_o;
  logic [2:0] sel_level_o, ext_line_o;
  logic       core_req_o, ext_valid_o;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_idx_i(evt_idx_i), .evt_active_i(evt_active_i),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
    .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
    .cur_level_i(cur_level_i), .ext_idx_i(ext_idx_i),
    .pend_o(pend_o), .en_o(en_o), .sel_level_o(sel_level_o),
    .core_req_o(core_req_o), .ext_line_o(ext_line_o), .ext_valid_o(ext_valid_o)
  );

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state, from the requirements
  bit [7:0] m_pend = '0;
  bit [7:0] m_en = '0;
  int       m_cur = 0;
  int       lvl_tab[8] = '{1, 2, 3, 4, 5, 1, 3, 5};
  bit [7:0] edge_m = 8'b1100_1010;

  function automatic int exp_sel();
    for (int lv = 5; lv >= 1; lv--)
      if (lv > m_cur)
        for (int i = 0; i < 8; i++)
          if (m_pend[i] && m_en[i] && lvl_tab[i] == lv) return lv;
    return 0;
  endfunction

  task automatic push(kind_e k, int exp, string tag);
    item_t it;
    it.k = k; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_all(string tag);
    int s;
    s = exp_sel();
    push(K_PEND, int'(m_pend), tag);
    push(K_EN, int'(m_en), tag);
    push(K_SEL, s, tag);
    push(K_REQ, (s != 0) ? 1 : 0, tag);
  endtask

  // monitor: checks queued expectations in the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.k)
          K_PEND:  act = int'(pend_o);
          K_EN:    act = int'(en_o);
          K_SEL:   act = int'(sel_level_o);
          K_REQ:   act = int'(core_req_o);
          K_EXTV:  act = int'(ext_valid_o);
          default: act = int'(ext_line_o);
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%s actual=%0h expected=%0h", it.tag, it.k.name(), act, it.exp);
        end
      end
    end
  end

  task automatic step(bit v, int idx, bit act, bit cw, bit [7:0] cd, string tag);
    bit [7:0] setv, relv, clrv;
    @(negedge clk);
    evt_valid_i = v; evt_idx_i = 4'(idx); evt_active_i = act;
    clr_we_i = cw; clr_wdata_i = cd;
    @(negedge clk);
    evt_valid_i = 0; clr_we_i = 0;
    setv = (v && idx < 8 && act) ? 8'(1 << idx) : 8'h0;
    relv = (v && idx < 8 && !act && !edge_m[idx % 8]) ? 8'(1 << idx) : 8'h0;
    clrv = cw ? (cd & edge_m) : 8'h0;
    m_pend = (m_pend & ~(relv | clrv)) | setv;
    #0.5 expect_all(tag);
  endtask

  task automatic wr_en(bit [7:0] d, string tag);
    @(negedge clk);
    en_we_i = 1; en_wdata_i = d;
    @(negedge clk);
    en_we_i = 0;
    m_en = d;
    #0.5 expect_all(tag);
  endtask

  task automatic set_cur(int c, string tag);
    @(negedge clk);
    cur_level_i = 3'(c);
    m_cur = c;
    #0.5 expect_all(tag);
  endtask

  task automatic ext_chk(int idx, int line, bit v, string tag);
    @(negedge clk);
    ext_idx_i = 2'(idx);
    #0.5;
    push(K_EXTV, int'(v), tag);
    push(K_EXTL, line, tag);
  endtask

  initial begin
    // R10: reset state, with writes attempted during reset
    @(negedge clk);
    en_we_i = 1; en_wdata_i = 8'hFF;
    evt_valid_i = 1; evt_idx_i = 4'd4; evt_active_i = 1;
    @(negedge clk);
    #0.5 expect_all("R10 in reset");
    @(negedge clk);
    en_we_i = 0; evt_valid_i = 0;
    rst_ni = 1;
    #0.5 expect_all("R10 after release");

    wr_en(8'hFF, "R4 enable all");
    step(1, 0, 1, 0, 8'h00, "R1 set line0 lvl1");
    step(1, 4, 1, 0, 8'h00, "R5 line4 lvl5 wins");
    set_cur(5, "R6 core at top level");
    set_cur(4, "R7 core lowered comb");
    set_cur(0, "R7 core zero");
    step(1, 1, 1, 0, 8'h00, "R1 set edge line1");
    step(1, 0, 0, 0, 8'h00, "R2 level line0 released");
    step(1, 1, 0, 0, 8'h00, "R2 edge line1 held");
    step(1, 8, 1, 0, 8'h00, "R3 idx8 ignored");
    step(1, 15, 0, 0, 8'h00, "R3 idx15 ignored");
    wr_en(8'hEF, "R4 line4 masked");
    set_cur(2, "R6 equal level no req");
    set_cur(1, "R5 just below");
    set_cur(0, "R5 core zero");
    step(1, 2, 1, 0, 8'h00, "R5 line2 lvl3");
    step(0, 0, 0, 1, 8'h06, "R9 w1c edge only");
    step(1, 3, 1, 1, 8'h08, "R9 set beats clear");
    step(0, 0, 0, 1, 8'h08, "R9 clear line3");
    step(1, 7, 1, 0, 8'h00, "R1 set edge line7");
    step(1, 7, 0, 0, 8'h00, "R2 edge line7 held");
    wr_en(8'h00, "R4 all disabled");
    ext_chk(0, 2, 1, "R8 ext0");
    ext_chk(1, 5, 1, "R8 ext1");
    ext_chk(2, 7, 1, "R8 ext2");
    ext_chk(3, 0, 0, "R8 ext3 invalid");

    @(negedge clk);
    #3;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule